// File: doc/BRIEF.md
# Two-Bank Flash Command Interpreter

This block decodes the command writes that a host issues to a flash device split into two independently operating banks. It watches a write strobe with address and data, recognises the two-write unlock preamble and the command word that follows, and keeps a separate mode for every bank: normal array read, identification (autoselect), read while an erase is suspended, busy programming, busy erasing, or failed. One device-wide power-saving flag is also held here; once set by its command, only a hardware reset clears it.

The embedded program and erase algorithms live outside. The block emits a one-cycle start pulse per bank when a program or erase begins, and an external engine answers with a per-bank done pulse or a timeout-error pulse. For the read path it tells, for a bank picked by the reader, whether data should come from the array, the identification codes or the operation status.

The rules on a reset command are the key behaviour. A reset aborts an unfinished sequence and leaves identification mode, but it cannot stop an operation that is running, and a bank that carries a suspended erase drops back to suspended-read rather than plain read.

Top module: `flash_cmd_fsm`

## Requirements
- R1: After reset every bank mode is 0 (read), ps_active is 0, no start pulse is high and rd_src is 0 (array).
- R2: A command is taken only after a write of AAh to low address 555h and then 55h to low address 2AAh (low address = bits 10:0); any write that breaks this order drops the decoder back to idle, so a following command byte acts as if no unlock was written.
- R3: Third-cycle write 70h at low address 555h sets ps_active; it stays set through later commands and is cleared only by rst_n.
- R4: Third-cycle write 90h enters identification mode (1) in the bank chosen by address bit 11 when that bank is in read (0) or suspended-read (2); rd_src then reads 1 for that bank on every cycle until a reset command.
- R5: The identification command is refused if the target bank is not in mode 0 or 2, or if the other bank is in program (3) or erase (4) at the start of that cycle.
- R6: A write of F0h at any address and in any decoder phase aborts the pending sequence and moves a bank in mode 1 or 5 to mode 2 if it holds a suspended erase, else to mode 0.
- R7: A bank in mode 3 or 4 keeps its mode across an F0h write.
- R8: Third-cycle A0h at low 555h, then one data write to any address, puts the bank named by bit 11 into program (3) with prog_go high for one cycle; done returns it to 0, or to 2 when the program was started from 2.
- R9: Erase takes six writes (AAh/555h, 55h/2AAh, 80h/555h, AAh/555h, 55h/2AAh, 30h to the bank); from mode 0 only it enters erase (4) with erase_go high one cycle; done returns it to 0.
- R10: From idle, B0h to a bank in erase moves it to suspended-read (2); 30h to a bank in mode 2 resumes erase (4) without a start pulse.
- R11: A timeout pulse in mode 3 or 4 moves the bank to failed (5), taking precedence over a done pulse in the same cycle.
- R12: rd_src for the bank named by rd_bank is 0 in modes 0 and 2, 1 in mode 1, and 2 in modes 3, 4 and 5.
- R13: A command written in the same cycle as a done or timeout pulse is judged against the bank modes held before that clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Write strobe, one write per high cycle |
| wr_addr | input | ADDR_W | Write address; top bit selects the bank |
| wr_data | input | 8 | Write data / command byte |
| op_done | input | NUM_BANKS | Per-bank operation-complete pulse |
| op_timeout | input | NUM_BANKS | Per-bank operation timeout-error pulse |
| rd_bank | input | BANK_W | Bank whose read source is reported |
| bank_mode | output | 3*NUM_BANKS | Mode of each bank, 3 bits per bank |
| ps_active | output | 1 | Power-saving mode flag |
| prog_go | output | NUM_BANKS | One-cycle program start pulse per bank |
| erase_go | output | NUM_BANKS | One-cycle erase start pulse per bank |
| rd_src | output | 2 | Read data source for rd_bank |

## Verification
The two functions that can meet in one cycle are command acceptance and the completion of an operation: a done or timeout pulse may arrive on the very edge at which an identification or reset write is sampled. The bench drives op_done on the cycle of an identification command aimed at the other bank, and op_timeout together with a reset write to the busy bank. It expects the identification to be refused and the reset to be ignored by the busy bank, while the same reset still takes the other bank out of identification.

// File: rtl/fcsm_pkg.sv
package fcsm_pkg;

  localparam int CMD_W  = 8;
  localparam int KEY_AW = 11;
  localparam int MODE_W = 3;

  localparam logic [KEY_AW-1:0] UNL_ADDR_A = 11'h555;
  localparam logic [KEY_AW-1:0] UNL_ADDR_B = 11'h2AA;

  localparam logic [CMD_W-1:0] KEY_A          = 8'hAA;
  localparam logic [CMD_W-1:0] KEY_B          = 8'h55;
  localparam logic [CMD_W-1:0] CODE_RESET     = 8'hF0;
  localparam logic [CMD_W-1:0] CODE_IDENT     = 8'h90;
  localparam logic [CMD_W-1:0] CODE_PSAVE     = 8'h70;
  localparam logic [CMD_W-1:0] CODE_PROG      = 8'hA0;
  localparam logic [CMD_W-1:0] CODE_ERS_SETUP = 8'h80;
  localparam logic [CMD_W-1:0] CODE_ERS_GO    = 8'h30;
  localparam logic [CMD_W-1:0] CODE_SUSPEND   = 8'hB0;
  localparam logic [CMD_W-1:0] CODE_RESUME    = 8'h30;

  typedef enum logic [MODE_W-1:0] {
    BM_READ    = 3'd0,
    BM_IDENT   = 3'd1,
    BM_SUSP_RD = 3'd2,
    BM_PROG    = 3'd3,
    BM_ERASE   = 3'd4,
    BM_FAIL    = 3'd5
  } bank_mode_e;

  typedef enum logic [2:0] {
    CK_NONE,
    CK_RESET,
    CK_IDENT,
    CK_PROG,
    CK_ERASE,
    CK_SUSPEND,
    CK_RESUME
  } cmd_kind_e;

  typedef enum logic [1:0] {
    RS_ARRAY  = 2'd0,
    RS_IDENT  = 2'd1,
    RS_STATUS = 2'd2
  } rd_src_e;

  typedef enum logic [2:0] {
    DS_IDLE,
    DS_UNL1,
    DS_UNL2,
    DS_PROG_DATA,
    DS_ERS_UNL0,
    DS_ERS_UNL1,
    DS_ERS_CONF
  } dec_state_e;

endpackage

// File: rtl/fcsm_decoder.sv
module fcsm_decoder
  import fcsm_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BANK_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CMD_W-1:0]  wr_data,
  output cmd_kind_e         cmd_kind,
  output logic [BANK_W-1:0] cmd_bank,
  output logic              ps_active
);

  dec_state_e st_q, st_nxt;
  logic       ps_q;
  logic       ps_set;
  logic       at_a, at_b;

  assign at_a     = (wr_addr[KEY_AW-1:0] == UNL_ADDR_A);
  assign at_b     = (wr_addr[KEY_AW-1:0] == UNL_ADDR_B);
  assign cmd_bank = wr_addr[ADDR_W-1 -: BANK_W];

  // Next-state and command event; a reset byte wins in every phase.
  always_comb begin
    st_nxt   = st_q;
    cmd_kind = CK_NONE;
    ps_set   = 1'b0;
    if (wr_en) begin
      if (wr_data == CODE_RESET) begin
        cmd_kind = CK_RESET;
        st_nxt   = DS_IDLE;
      end else begin
        st_nxt = DS_IDLE;
        case (st_q)
          DS_IDLE: begin
            if (at_a && wr_data == KEY_A)    st_nxt   = DS_UNL1;
            else if (wr_data == CODE_SUSPEND) cmd_kind = CK_SUSPEND;
            else if (wr_data == CODE_RESUME)  cmd_kind = CK_RESUME;
          end
          DS_UNL1: begin
            if (at_b && wr_data == KEY_B) st_nxt = DS_UNL2;
          end
          DS_UNL2: begin
            if (wr_data == CODE_IDENT)                 cmd_kind = CK_IDENT;
            else if (at_a && wr_data == CODE_PSAVE)     ps_set   = 1'b1;
            else if (at_a && wr_data == CODE_PROG)      st_nxt   = DS_PROG_DATA;
            else if (at_a && wr_data == CODE_ERS_SETUP) st_nxt   = DS_ERS_UNL0;
          end
          DS_PROG_DATA: begin
            cmd_kind = CK_PROG;
          end
          DS_ERS_UNL0: begin
            if (at_a && wr_data == KEY_A) st_nxt = DS_ERS_UNL1;
          end
          DS_ERS_UNL1: begin
            if (at_b && wr_data == KEY_B) st_nxt = DS_ERS_CONF;
          end
          DS_ERS_CONF: begin
            if (wr_data == CODE_ERS_GO) cmd_kind = CK_ERASE;
          end
          default: st_nxt = DS_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= DS_IDLE;
    end else if (wr_en) begin
      st_q <= st_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q <= 1'b0;
    end else if (ps_set) begin
      ps_q <= 1'b1;
    end
  end

  assign ps_active = ps_q;

endmodule

// File: rtl/fcsm_bank.sv
module fcsm_bank
  import fcsm_pkg::*;
#(
  parameter int BANK_W = 1,
  parameter int IDX    = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_kind_e         cmd_kind,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic              peer_busy,
  input  logic              op_done,
  input  logic              op_timeout,
  output bank_mode_e        mode,
  output logic              busy,
  output logic              prog_go,
  output logic              erase_go
);

  localparam logic [BANK_W-1:0] MY_ID = BANK_W'(IDX);

  bank_mode_e mode_q, mode_nxt;
  logic       susp_q, susp_nxt;
  logic       pg_q, pg_nxt;
  logic       er_q, er_nxt;
  logic       hit;
  logic       upd;

  assign hit = (cmd_bank == MY_ID);

  always_comb begin
    mode_nxt = mode_q;
    susp_nxt = susp_q;
    pg_nxt   = 1'b0;
    er_nxt   = 1'b0;
    case (mode_q)
      BM_PROG, BM_ERASE: begin
        // Running operation: only the engine handshake or a suspend moves it.
        if (op_timeout) begin
          mode_nxt = BM_FAIL;
        end else if (op_done) begin
          if (mode_q == BM_PROG) begin
            mode_nxt = susp_q ? BM_SUSP_RD : BM_READ;
          end else begin
            mode_nxt = BM_READ;
            susp_nxt = 1'b0;
          end
        end else if (mode_q == BM_ERASE && hit && cmd_kind == CK_SUSPEND) begin
          mode_nxt = BM_SUSP_RD;
          susp_nxt = 1'b1;
        end
      end
      BM_IDENT, BM_FAIL: begin
        if (cmd_kind == CK_RESET) begin
          mode_nxt = susp_q ? BM_SUSP_RD : BM_READ;
        end
      end
      BM_READ, BM_SUSP_RD: begin
        if (hit) begin
          case (cmd_kind)
            CK_IDENT: begin
              if (!peer_busy) mode_nxt = BM_IDENT;
            end
            CK_PROG: begin
              mode_nxt = BM_PROG;
              pg_nxt   = 1'b1;
            end
            CK_ERASE: begin
              if (mode_q == BM_READ) begin
                mode_nxt = BM_ERASE;
                er_nxt   = 1'b1;
              end
            end
            CK_RESUME: begin
              if (mode_q == BM_SUSP_RD) begin
                mode_nxt = BM_ERASE;
                susp_nxt = 1'b0;
              end
            end
            default: ;
          endcase
        end
      end
      default: begin
        mode_nxt = BM_READ;
        susp_nxt = 1'b0;
      end
    endcase
  end

  assign upd = (mode_nxt != mode_q) || (susp_nxt != susp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= BM_READ;
      susp_q <= 1'b0;
    end else if (upd) begin
      mode_q <= mode_nxt;
      susp_q <= susp_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_q <= 1'b0;
      er_q <= 1'b0;
    end else begin
      pg_q <= pg_nxt;
      er_q <= er_nxt;
    end
  end

  assign mode     = mode_q;
  assign busy     = (mode_q == BM_PROG) || (mode_q == BM_ERASE);
  assign prog_go  = pg_q;
  assign erase_go = er_q;

endmodule

// File: rtl/fcsm_rd_sel.sv
module fcsm_rd_sel
  import fcsm_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 1
) (
  input  logic [NUM_BANKS*MODE_W-1:0] modes_flat,
  input  logic [BANK_W-1:0]           rd_bank,
  output rd_src_e                     rd_src
);

  logic [MODE_W-1:0] sel_mode;

  assign sel_mode = modes_flat[MODE_W*int'(rd_bank) +: MODE_W];

  always_comb begin
    case (bank_mode_e'(sel_mode))
      BM_IDENT:                    rd_src = RS_IDENT;
      BM_PROG, BM_ERASE, BM_FAIL:  rd_src = RS_STATUS;
      default:                     rd_src = RS_ARRAY;
    endcase
  end

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import fcsm_pkg::*;
#(
  parameter int NUM_BANKS   = 2,
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2,
  localparam int BANK_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [7:0]                  wr_data,
  input  logic [NUM_BANKS-1:0]        op_done,
  input  logic [NUM_BANKS-1:0]        op_timeout,
  input  logic [BANK_W-1:0]           rd_bank,
  output logic [NUM_BANKS*MODE_W-1:0] bank_mode,
  output logic                        ps_active,
  output logic [NUM_BANKS-1:0]        prog_go,
  output logic [NUM_BANKS-1:0]        erase_go,
  output logic [1:0]                  rd_src
);

  // Asynchronous assertion, synchronous release.
  logic [SYNC_STAGES-1:0] rs_q;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= '0;
    end else begin
      rs_q <= {rs_q[SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign rst_int_n = rs_q[SYNC_STAGES-1];

  cmd_kind_e         cmd_kind;
  logic [BANK_W-1:0] cmd_bank;
  logic [NUM_BANKS-1:0] busy_vec;
  logic [NUM_BANKS-1:0] peer_busy;
  bank_mode_e        mode_w [NUM_BANKS];
  rd_src_e           src_w;

  fcsm_decoder #(
    .ADDR_W (ADDR_W),
    .BANK_W (BANK_W)
  ) u_dec (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .cmd_kind  (cmd_kind),
    .cmd_bank  (cmd_bank),
    .ps_active (ps_active)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    assign peer_busy[g] = |(busy_vec & ~(NUM_BANKS'(1) << g));

    fcsm_bank #(
      .BANK_W (BANK_W),
      .IDX    (g)
    ) u_bank (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .cmd_kind   (cmd_kind),
      .cmd_bank   (cmd_bank),
      .peer_busy  (peer_busy[g]),
      .op_done    (op_done[g]),
      .op_timeout (op_timeout[g]),
      .mode       (mode_w[g]),
      .busy       (busy_vec[g]),
      .prog_go    (prog_go[g]),
      .erase_go   (erase_go[g])
    );

    assign bank_mode[MODE_W*g +: MODE_W] = mode_w[g];
  end

  fcsm_rd_sel #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W)
  ) u_rd_sel (
    .modes_flat (bank_mode),
    .rd_bank    (rd_bank),
    .rd_src     (src_w)
  );

  assign rd_src = src_w;

endmodule

// File: rtl/fcsm_chk.sv
module fcsm_chk
  import fcsm_pkg::*;
#(
  parameter int NUM_BANKS = 2
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        wr_en,
  input logic [7:0]                  wr_data,
  input logic [NUM_BANKS-1:0]        op_done,
  input logic [NUM_BANKS-1:0]        op_timeout,
  input logic [NUM_BANKS*MODE_W-1:0] bank_mode,
  input logic                        ps_active,
  input logic [NUM_BANKS-1:0]        prog_go,
  input logic [NUM_BANKS-1:0]        erase_go,
  input logic [1:0]                  rd_src
);

  p_ps_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ps_active |=> ps_active);

  p_one_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_go, erase_go}));

  p_src_legal_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_src != 2'b11);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_chk
    logic [MODE_W-1:0] m;
    logic              m_busy;
    logic              peer_bsy;

    assign m      = bank_mode[MODE_W*g +: MODE_W];
    assign m_busy = (m == BM_PROG) || (m == BM_ERASE);

    always_comb begin
      peer_bsy = 1'b0;
      for (int k = 0; k < NUM_BANKS; k++) begin
        if (k != g && (bank_mode[MODE_W*k +: MODE_W] == BM_PROG ||
                       bank_mode[MODE_W*k +: MODE_W] == BM_ERASE)) begin
          peer_bsy = 1'b1;
        end
      end
    end

    p_busy_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (m_busy && wr_en && wr_data == CODE_RESET && !op_done[g] && !op_timeout[g])
        |=> (m == $past(m)));

    p_timeout_fail_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (m_busy && op_timeout[g]) |=> (m == BM_FAIL));

    p_ident_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (m != BM_IDENT && peer_bsy) |=> (m != BM_IDENT));

    p_prog_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      prog_go[g] |-> (m == BM_PROG));

    p_erase_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      erase_go[g] |-> (m == BM_ERASE));
  end

endmodule

bind flash_cmd_fsm fcsm_chk #(
  .NUM_BANKS (NUM_BANKS)
) u_fcsm_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .op_done    (op_done),
  .op_timeout (op_timeout),
  .bank_mode  (bank_mode),
  .ps_active  (ps_active),
  .prog_go    (prog_go),
  .erase_go   (erase_go),
  .rd_src     (rd_src)
);

// File: tb/flash_cmd_fsm_bench.sv
`timescale 1ns/1ps
module flash_cmd_fsm_bench;

  localparam logic [2:0] M_RD  = 3'd0;
  localparam logic [2:0] M_ID  = 3'd1;
  localparam logic [2:0] M_SR  = 3'd2;
  localparam logic [2:0] M_PG  = 3'd3;
  localparam logic [2:0] M_ER  = 3'd4;
  localparam logic [2:0] M_FL  = 3'd5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [11:0] wr_addr;
  logic [7:0]  wr_data;
  logic [1:0]  op_done;
  logic [1:0]  op_timeout;
  logic        rd_bank;
  logic [5:0]  bank_mode;
  logic        ps_active;
  logic [1:0]  prog_go;
  logic [1:0]  erase_go;
  logic [1:0]  rd_src;

  always #4 clk = ~clk;

  flash_cmd_fsm u_flash_cmd_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .op_done    (op_done),
    .op_timeout (op_timeout),
    .rd_bank    (rd_bank),
    .bank_mode  (bank_mode),
    .ps_active  (ps_active),
    .prog_go    (prog_go),
    .erase_go   (erase_go),
    .rd_src     (rd_src)
  );

  typedef struct {
    int          due;
    logic [12:0] exp;
    string       req;
  } item_t;

  item_t sb_q[$];
  int    cyc    = 0;
  int    n_chk  = 0;
  int    n_bad  = 0;
  bit    ended  = 1'b0;

  logic [2:0] em0 = M_RD;
  logic [2:0] em1 = M_RD;
  logic       eps = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [1:0] src_of(input logic [2:0] m);
    if (m == M_ID) return 2'd1;
    if (m == M_PG || m == M_ER || m == M_FL) return 2'd2;
    return 2'd0;
  endfunction

  // Driver: apply one cycle of stimulus and queue the state expected after its edge.
  task automatic step(input logic w, input logic [11:0] a, input logic [7:0] d,
                      input logic [1:0] dn, input logic [1:0] to, input logic rb,
                      input logic [1:0] pg, input logic [1:0] er, input string req);
    item_t it;
    @(negedge clk);
    wr_en = w; wr_addr = a; wr_data = d;
    op_done = dn; op_timeout = to; rd_bank = rb;
    it.due = cyc + 1;
    it.exp = {src_of(rb ? em1 : em0), pg, er, eps, em1, em0};
    it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic idle(input logic rb, input string req);
    step(1'b0, 12'h000, 8'h00, 2'b00, 2'b00, rb, 2'b00, 2'b00, req);
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d, input string req);
    step(1'b1, a, d, 2'b00, 2'b00, 1'b0, 2'b00, 2'b00, req);
  endtask

  task automatic unlock(input string req);
    wr(12'h555, 8'hAA, req);
    wr(12'h2AA, 8'h55, req);
  endtask

  task automatic erase_seq(input logic b, input string req);
    unlock(req);
    wr(12'h555, 8'h80, req);
    unlock(req);
    if (b) em1 = M_ER; else em0 = M_ER;
    step(1'b1, {b, 11'h000}, 8'h30, 2'b00, 2'b00, b, 2'b00, b ? 2'b10 : 2'b01, req);
  endtask

  task automatic prog_seq(input logic b, input logic [10:0] off, input string req);
    unlock(req);
    wr(12'h555, 8'hA0, req);
    if (b) em1 = M_PG; else em0 = M_PG;
    step(1'b1, {b, off}, 8'h5A, 2'b00, 2'b00, b, b ? 2'b10 : 2'b01, 2'b00, req);
  endtask

  task automatic hw_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wr_en = 1'b0; op_done = 2'b00; op_timeout = 2'b00;
    em0 = M_RD; em1 = M_RD; eps = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Monitor: compare queued expectations just after the edge they belong to.
  initial begin
    item_t       it;
    logic [12:0] obs;
    forever begin
      @(posedge clk);
      #2;
      while (sb_q.size() > 0 && sb_q[0].due == cyc) begin
        it  = sb_q.pop_front();
        obs = {rd_src, prog_go, erase_go, ps_active, bank_mode};
        n_chk++;
        if (obs !== it.exp) begin
          n_bad++;
          $display("FAIL %s: {src,pg,er,ps,m1,m0} got %b expected %b", it.req, obs, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      n_bad++;
      $display("FAIL watchdog: run did not complete, got hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    op_done = '0; op_timeout = '0; rd_bank = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state on both banks
    idle(1'b0, "R1"); idle(1'b1, "R1"); idle(1'b0, "R1"); idle(1'b0, "R1");

    // R2: broken unlock, then a command byte has no effect
    wr(12'h555, 8'hAA, "R2");
    wr(12'h2AA, 8'h56, "R2");
    wr(12'h800, 8'h90, "R2");
    idle(1'b1, "R2");

    // R4: identification in bank 1, read repeatedly
    unlock("R4");
    em1 = M_ID;
    wr(12'h800, 8'h90, "R4");
    idle(1'b1, "R4"); idle(1'b1, "R4"); idle(1'b0, "R12");

    // R6: reset at an arbitrary address leaves identification
    em1 = M_RD;
    wr(12'h3C1, 8'hF0, "R6");

    // R3: power saving set and held
    unlock("R3");
    eps = 1'b1;
    wr(12'h555, 8'h70, "R3");
    idle(1'b0, "R3"); idle(1'b0, "R3");

    // R8: program bank 0
    prog_seq(1'b0, 11'h123, "R8");
    idle(1'b0, "R12");

    // R7: reset ignored while programming
    wr(12'h000, 8'hF0, "R7");

    // R5: identification refused on a busy bank and on a bank whose peer is busy
    unlock("R5"); wr(12'h000, 8'h90, "R5");
    unlock("R5"); wr(12'h800, 8'h90, "R5");

    // R8: done returns to read
    em0 = M_RD;
    step(1'b0, 12'h000, 8'h00, 2'b01, 2'b00, 1'b0, 2'b00, 2'b00, "R8");

    // R9: six-write erase on bank 1
    erase_seq(1'b1, "R9");
    idle(1'b1, "R12");

    // R10: suspend
    em1 = M_SR;
    wr(12'h800, 8'hB0, "R10");
    idle(1'b1, "R12");

    // R4 from suspended-read, then R6 reset returns to suspended-read
    unlock("R4");
    em1 = M_ID;
    wr(12'h800, 8'h90, "R4");
    em1 = M_SR;
    wr(12'h123, 8'hF0, "R6");

    // R8: program inside the suspended bank returns to suspended-read
    prog_seq(1'b1, 11'h100, "R8");
    em1 = M_SR;
    step(1'b0, 12'h000, 8'h00, 2'b10, 2'b00, 1'b1, 2'b00, 2'b00, "R8");

    // R6: reset aborts a half-written erase; the next 30h acts as a resume (R10)
    unlock("R6");
    wr(12'h555, 8'h80, "R6");
    wr(12'h555, 8'hAA, "R6");
    wr(12'h000, 8'hF0, "R6");
    em1 = M_ER;
    wr(12'h800, 8'h30, "R10");

    // R11: timeout wins over done; reset leaves failed to read
    em1 = M_FL;
    step(1'b0, 12'h000, 8'h00, 2'b10, 2'b10, 1'b1, 2'b00, 2'b00, "R11");
    em1 = M_RD;
    wr(12'h800, 8'hF0, "R11");

    // R13: done of bank 0 in the same cycle as identification to bank 1
    erase_seq(1'b0, "R13");
    unlock("R13");
    em0 = M_RD;
    step(1'b1, 12'h800, 8'h90, 2'b01, 2'b00, 1'b1, 2'b00, 2'b00, "R13");
    unlock("R4");
    em1 = M_ID;
    wr(12'h800, 8'h90, "R4");

    // R13: timeout and reset in one cycle; bank 1 still leaves identification
    erase_seq(1'b0, "R13");
    em0 = M_FL; em1 = M_RD;
    step(1'b1, 12'h000, 8'hF0, 2'b00, 2'b01, 1'b0, 2'b00, 2'b00, "R13");
    em0 = M_RD;
    wr(12'h000, 8'hF0, "R11");

    // R11: failure of a program inside a suspended erase resets to suspended-read
    erase_seq(1'b0, "R9");
    em0 = M_SR;
    wr(12'h000, 8'hB0, "R10");
    prog_seq(1'b0, 11'h010, "R8");
    em0 = M_FL;
    step(1'b0, 12'h000, 8'h00, 2'b00, 2'b01, 1'b0, 2'b00, 2'b00, "R11");
    em0 = M_SR;
    wr(12'h000, 8'hF0, "R11");
    em0 = M_ER;
    wr(12'h000, 8'h30, "R10");
    em0 = M_RD;
    step(1'b0, 12'h000, 8'h00, 2'b01, 2'b00, 1'b0, 2'b00, 2'b00, "R9");

    // R3: only the hardware reset clears power saving
    hw_reset();
    idle(1'b0, "R3"); idle(1'b0, "R1"); idle(1'b1, "R3");

    repeat (4) @(negedge clk);
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule